// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block is the digital side of an analog comparator. It holds one 8-bit control and status register that software reads and writes through a simple bus port. The comparator result arrives as an asynchronous level and is synchronized to the bus clock. Each synchronized transition is checked against a selectable edge type. A matching transition sets a sticky interrupt flag, which raises an interrupt request when interrupts are enabled.

The block also drives three signals to the analog and pad side:
- a hysteresis select level for the comparator;
- an output enable for the external pin;
- the synchronized comparator result for that pin.

The comparator, its hysteresis network and the pad are outside this block. On the bench the comparator output is an ordinary input.

Top module: `cmp_edge_irq`

## Requirements
- R1: After reset every register bit reads 0, and `irq`, `hyst_sel`, `pad_oe` and `pad_out` are 0.
- R2: The register layout is: bit 7 enable, bit 6 hysteresis select, bit 5 interrupt flag, bit 4 interrupt enable, bit 3 comparator status, bit 2 pin enable, bits 1:0 edge mode. A write (`wr_en` high at a clock edge) loads bits 7, 6, 4, 2 and 1:0 from `wr_data`, and `rd_data` shows them after that edge. The value written to bit 3 is ignored.
- R3: Bit 3 shows the synchronized comparator level. A change of `cmp_async` placed between two clock edges appears after the second rising edge that follows it. Bit 3 reads 0 while bit 7 is 0.
- R4: Edge mode 00 sets the flag on a falling synchronized transition only, and edge mode 01 sets it on a rising one only.
- R5: Edge modes 10 and 11 set the flag on both rising and falling transitions.
- R6: The flag sets on the clock edge after bit 3 first shows the selected transition, which is the third rising edge after the input change.
- R7: A write with bit 5 = 0 clears the flag. A write with bit 5 = 1 leaves the flag as it was.
- R8: If a qualifying transition and a clearing write fall on the same clock edge, the flag ends up set.
- R9: While bit 7 is 0:
  - the synchronizer and the previous-sample register are held at 0;
  - no flag can be set;
  - a flag that is already set keeps its value.
  Enabling while `cmp_async` is high is therefore seen as a rising transition.
- R10: `irq` is 1 exactly when the flag (bit 5) and the interrupt enable (bit 4) are both 1.
- R11: `pad_oe` equals bit 2. `pad_out` equals bit 3 when bit 2 is 1, and is 0 otherwise.
- R12: `hyst_sel` equals bit 6 of the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| cmp_async | input | 1 | Raw comparator output, asynchronous |
| irq | output | 1 | Interrupt request |
| hyst_sel | output | 1 | Hysteresis level select to the analog side |
| pad_oe | output | 1 | External pin output enable |
| pad_out | output | 1 | Comparator result for the external pin |

## Verification
The assertions assume that `wr_data` only matters while `wr_en` is high. They also assume that `cmp_async` is a plain level whose transitions reach the synchronizer as single clean steps. The stimulus changes `cmp_async` and the bus inputs only between clock edges. It holds each comparator level for at least three edges, so every transition is fully resolved before the next one arrives.

The one same-edge collision the design must arbitrate, a set against a clear, is produced on purpose by timing a clearing write onto the flag-set edge. Disabled periods are covered by toggling the input with bit 7 at 0 and then enabling while the input is high.

// File: rtl/cmp_edge_pkg.sv
`timescale 1ns/1ps
package cmp_edge_pkg;
   localparam int unsigned REG_W    = 8;
   localparam int unsigned BIT_EN   = 7;
   localparam int unsigned BIT_HSEL = 6;
   localparam int unsigned BIT_FLG  = 5;
   localparam int unsigned BIT_IEN  = 4;
   localparam int unsigned BIT_STAT = 3;
   localparam int unsigned BIT_PEN  = 2;
   localparam int unsigned BIT_MODE = 0;
   localparam int unsigned MODE_W   = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_FALL  = 2'b00,
      MODE_RISE  = 2'b01,
      MODE_ANY_A = 2'b10,
      MODE_ANY_B = 2'b11
   } edge_mode_e;

   typedef struct packed {
      logic       en;
      logic       hsel;
      logic       ien;
      logic       pen;
      edge_mode_e mode;
   } ctrl_t;
endpackage

// File: rtl/cmp_sync_edge.sv
`timescale 1ns/1ps
module cmp_sync_edge
   import cmp_edge_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RSVD_BOTH   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  edge_mode_e mode,
   input  logic       async_in,
   output logic       sync_out,
   output logic       edge_hit
);
   localparam int unsigned LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("cmp_sync_edge: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;
   logic                   rise, fall;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
         prev_q  <= chain_q[LAST];
      end
   end

   assign sync_out = chain_q[LAST];
   assign rise     = sync_out & ~prev_q;
   assign fall     = ~sync_out & prev_q;

   if (RSVD_BOTH) begin : g_rsvd_both
      always_comb begin
         if (mode[1])      edge_hit = rise | fall;
         else if (mode[0]) edge_hit = rise;
         else              edge_hit = fall;
      end
   end else begin : g_rsvd_none
      always_comb begin
         if (mode[1])      edge_hit = 1'b0;
         else if (mode[0]) edge_hit = rise;
         else              edge_hit = fall;
      end
   end

   // R9
   dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !sync_out);

   // R4
   rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_RISE && edge_hit) |-> sync_out);
endmodule

// File: rtl/cmp_ctrl_reg.sv
`timescale 1ns/1ps
module cmp_ctrl_reg
   import cmp_edge_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             edge_hit,
   input  logic             stat,
   output ctrl_t            ctrl,
   output logic             flg,
   output logic [REG_W-1:0] rd_data
);
   ctrl_t ctrl_q;
   logic  flg_q;
   logic  set_now;
   logic  clr_now;
   logic  wr_stat_unused;

   assign wr_stat_unused = wr_data[BIT_STAT];
   assign set_now = ctrl_q.en & edge_hit;
   assign clr_now = wr_en & ~wr_data[BIT_FLG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q.en   <= wr_data[BIT_EN];
         ctrl_q.hsel <= wr_data[BIT_HSEL];
         ctrl_q.ien  <= wr_data[BIT_IEN];
         ctrl_q.pen  <= wr_data[BIT_PEN];
         ctrl_q.mode <= edge_mode_e'(wr_data[BIT_MODE +: MODE_W]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       flg_q <= 1'b0;
      else if (set_now) flg_q <= 1'b1;
      else if (clr_now) flg_q <= 1'b0;
   end

   always_comb begin
      rd_data                     = '0;
      rd_data[BIT_EN]             = ctrl_q.en;
      rd_data[BIT_HSEL]           = ctrl_q.hsel;
      rd_data[BIT_FLG]            = flg_q;
      rd_data[BIT_IEN]            = ctrl_q.ien;
      rd_data[BIT_STAT]           = stat;
      rd_data[BIT_PEN]            = ctrl_q.pen;
      rd_data[BIT_MODE +: MODE_W] = ctrl_q.mode;
   end

   assign ctrl = ctrl_q;
   assign flg  = flg_q;

   // R7
   wr_one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BIT_FLG] && flg_q) |=> flg_q);

   // R7
   wr_zero_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[BIT_FLG] && !edge_hit) |=> !flg_q);

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.en && edge_hit) |=> flg_q);

   // R9
   no_set_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.en && !flg_q) |=> !flg_q);
endmodule

// File: rtl/cmp_edge_irq.sv
`timescale 1ns/1ps
module cmp_edge_irq
   import cmp_edge_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RSVD_BOTH   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   input  logic       cmp_async,
   output logic       irq,
   output logic       hyst_sel,
   output logic       pad_oe,
   output logic       pad_out
);
   if (REG_W != 8) begin : g_bad_width
      $error("cmp_edge_irq: register width must be 8");
   end

   ctrl_t ctrl;
   logic  flg;
   logic  sync_lvl;
   logic  edge_hit;
   logic  stat;

   cmp_sync_edge #(
      .SYNC_STAGES (SYNC_STAGES),
      .RSVD_BOTH   (RSVD_BOTH)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl.en),
      .mode     (ctrl.mode),
      .async_in (cmp_async),
      .sync_out (sync_lvl),
      .edge_hit (edge_hit)
   );

   assign stat = ctrl.en & sync_lvl;

   cmp_ctrl_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .edge_hit (edge_hit),
      .stat     (stat),
      .ctrl     (ctrl),
      .flg      (flg),
      .rd_data  (rd_data)
   );

   assign irq      = flg & ctrl.ien;
   assign hyst_sel = ctrl.hsel;
   assign pad_oe   = ctrl.pen;
   assign pad_out  = ctrl.pen & stat;

   // R6
   flag_follows_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.en && sync_lvl && ctrl.mode == MODE_RISE && !flg && $rose(rd_data[BIT_STAT]))
      |=> rd_data[BIT_FLG]);
endmodule

// File: tb/cmp_edge_irq_tb.sv
`timescale 1ns/1ps
module cmp_edge_irq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       cmp_async = 1'b0;
   logic       irq, hyst_sel, pad_oe, pad_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [7:0] rd;
      logic       irq;
      logic       oe;
      logic       po;
      logic       hy;
      string      tag;
   } exp_t;

   exp_t sb_q[$];

   always #10 clk = ~clk;

   cmp_edge_irq u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .cmp_async (cmp_async),
      .irq       (irq),
      .hyst_sel  (hyst_sel),
      .pad_oe    (pad_oe),
      .pad_out   (pad_out)
   );

   // monitor: compares one expected item per falling edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_chk++;
         if (rd_data !== e.rd || irq !== e.irq || pad_oe !== e.oe ||
             pad_out !== e.po || hyst_sel !== e.hy) begin
            n_fail++;
            $display("FAIL %s: rd=%02h irq=%b oe=%b po=%b hy=%b expected rd=%02h irq=%b oe=%b po=%b hy=%b",
                     e.tag, rd_data, irq, pad_oe, pad_out, hyst_sel,
                     e.rd, e.irq, e.oe, e.po, e.hy);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [7:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      @(posedge clk);
      #2;
      wr_en   = 1'b0;
   endtask

   // expected outputs derived from a register image
   task automatic expect_reg(input logic [7:0] r, input string tag);
      exp_t e;
      e.rd  = r;
      e.irq = r[5] & r[4];
      e.oe  = r[2];
      e.po  = r[2] & r[3];
      e.hy  = r[6];
      e.tag = tag;
      sb_q.push_back(e);
      wait (sb_q.size() == 0);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      expect_reg(8'h00, "R1 reset state");

      cmp_async = 1'b1;
      tick(4);
      expect_reg(8'h00, "R3 R9 disabled input ignored");

      cmp_async = 1'b0;
      wr(8'h95);
      expect_reg(8'h95, "R2 R11 write readback");

      cmp_async = 1'b1;
      tick(2);
      expect_reg(8'h9D, "R3 status after two edges, R6 no flag yet");
      tick(1);
      expect_reg(8'hBD, "R4 R6 R10 rising flag and irq");

      wr(8'hBD);
      expect_reg(8'hBD, "R7 write one keeps flag");
      wr(8'hA5);
      expect_reg(8'hAD, "R10 irq masked, R2 status write ignored");
      wr(8'h85);
      expect_reg(8'h8D, "R7 write zero clears flag");

      cmp_async = 1'b0;
      tick(4);
      expect_reg(8'h85, "R4 falling ignored in rise mode");

      wr(8'h94);
      cmp_async = 1'b1;
      tick(4);
      expect_reg(8'h9C, "R4 rising ignored in fall mode");
      cmp_async = 1'b0;
      tick(2);
      expect_reg(8'h94, "R6 fall no flag yet");
      tick(1);
      expect_reg(8'hB4, "R4 falling flag");

      wr(8'h96);
      expect_reg(8'h96, "R7 clear in mode 10");
      cmp_async = 1'b1;
      tick(3);
      expect_reg(8'hBE, "R5 mode 10 rising");
      wr(8'h96);
      expect_reg(8'h9E, "R7 clear");
      cmp_async = 1'b0;
      tick(3);
      expect_reg(8'hB6, "R5 mode 10 falling");
      wr(8'h97);
      expect_reg(8'h97, "R7 clear mode 11");
      cmp_async = 1'b1;
      tick(3);
      expect_reg(8'hBF, "R5 mode 11 rising");
      wr(8'h97);
      expect_reg(8'h9F, "R7 clear before collision");

      cmp_async = 1'b0;
      tick(2);
      wr(8'h97);
      expect_reg(8'hB7, "R8 set wins over clear");

      wr(8'hD7);
      expect_reg(8'hD7, "R12 hysteresis select");
      wr(8'hDF);
      expect_reg(8'hD7, "R2 status bit write ignored");

      wr(8'hD3);
      cmp_async = 1'b1;
      tick(2);
      expect_reg(8'hDB, "R11 pin disabled, pad_out low");
      tick(1);
      expect_reg(8'hFB, "R5 flag with pin disabled");

      wr(8'h7B);
      expect_reg(8'h73, "R3 R9 disable keeps flag, status zero");
      cmp_async = 1'b0;
      tick(4);
      cmp_async = 1'b1;
      tick(4);
      expect_reg(8'h73, "R9 disabled flag unchanged");
      wr(8'h53);
      expect_reg(8'h53, "R7 clear while disabled");
      cmp_async = 1'b0;
      tick(4);
      cmp_async = 1'b1;
      tick(4);
      expect_reg(8'h53, "R9 no set while disabled");

      wr(8'hD3);
      expect_reg(8'hD3, "R9 enable, history at zero");
      tick(2);
      expect_reg(8'hDB, "R3 status after enable");
      tick(1);
      expect_reg(8'hFB, "R9 enable with input high gives rising flag");

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule